// File: doc/BRIEF.md
# SDRAM command timing sequencer

The block sits between a simple host request port and a four-bank, 16-bit synchronous DRAM. It turns single-word read and write requests, each carrying a 2-bit bank, a 13-bit row and a 9-bit column, into the chip-select, row-strobe, column-strobe and write-enable command patterns the memory expects. It also drives the bank, address and data-mask pins. Every access opens a row with an activate command. The access then finishes with a column command that sets the auto-precharge flag, so the sequencer never needs to keep track of which rows are open.

After reset the sequencer waits for a power-up interval that a parameter sets short. It then precharges all banks and programs the mode register for single-word bursts, sequential order and the CAS latency chosen on an input pin. That latency can be changed while the block runs. When the pin disagrees with the programmed value, the idle sequencer reprograms the mode register before it accepts the next request. Read data is captured by a countdown that is loaded with the latency in force when the read command went out.

States: INIT_WAIT, INIT_PRE, PRE_WAIT, LOAD_MODE, MODE_WAIT, IDLE, ACTIVATE, RCD_WAIT, COLUMN, RECOVER. Transitions:
- power-up: INIT_WAIT→INIT_PRE when the timer expires.
- init precharge: INIT_PRE→PRE_WAIT→LOAD_MODE.
- mode settle: LOAD_MODE→MODE_WAIT→IDLE.
- latency change: IDLE→LOAD_MODE.
- accept: IDLE→ACTIVATE.
- row open: ACTIVATE→RCD_WAIT→COLUMN.
- recovery: COLUMN→RECOVER→IDLE.

Top module: `sdram_seq`

## Requirements
- R1: While reset is low, the command pins carry NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), sd_dqm is 1, and req_ready and rsp_valid are 0.
- R2: After reset, at least T_INIT cycles of NOP pass. The first command is then a precharge with sd_addr[10]=1, and a mode-register-set follows exactly T_RP cycles after it.
- R3: A mode-register-set (0,0,0,0) drives sd_ba=0 and sd_addr=0x020 for CAS latency 2 (cas_lat3=0) or 0x030 for latency 3 (cas_lat3=1). The field layout is: bits 2:0 burst length 1 = 000, bit 3 sequential = 0, bits 6:4 latency, all other bits 0.
- R4: A read (0,1,0,1) or write (0,1,0,0) comes exactly T_RCD cycles after the activate (0,0,1,1) of the same request. It uses the request's bank, places the column on sd_addr[8:0] and sets sd_addr[10]=1 (auto-precharge).
- R5: Two activates are at least T_RC cycles apart. An activate comes at least max(T_RC-T_RCD, T_DPL+T_RP) cycles after the preceding column command.
- R6: sd_dq_oe is 1 only in the cycle of a write command. In that cycle sd_dq_out carries the request's write data and sd_dqm is 0.
- R7: Read data present on sd_dq_in CL clock edges after the edge that samples the read command is returned on rsp_rdata. rsp_valid is high for exactly one cycle, starting CL+1 cycles after the read command cycle.
- R8: req_ready is high only in IDLE, and only when cas_lat3 matches the programmed latency. Each handshake yields exactly one activate, and req_ready is low in the cycle after acceptance.
- R9: When cas_lat3 differs from the programmed latency in IDLE, a new mode-register-set is issued before the next activate, even when a request is waiting in the same cycle. Later reads use the new latency.
- R10: Every cycle without a due command carries NOP, and no command follows a mode-register-set within fewer than T_MRD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | Requested CAS latency: 1 selects 3, 0 selects 2 |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 13 | Row of the request |
| req_col | input | 9 | Column of the request |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Captured read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column/mode address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Read data from memory |

## Verification
Two events can fall in the same idle cycle: a change of the latency pin and a pending host request. The mode-register rewrite must win, and the request must wait for it. The bench provokes this by flipping cas_lat3 at the same moment it raises req_valid with a read. It then judges three things: req_ready stays low, a mode-register-set carrying the new latency field comes before the activate, and the read data returns exactly CL+1 cycles after the read command under the new latency.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } sd_cmd_t;

    typedef enum logic [3:0] {
        ST_INIT_WAIT,
        ST_INIT_PRE,
        ST_PRE_WAIT,
        ST_LOAD_MODE,
        ST_MODE_WAIT,
        ST_IDLE,
        ST_ACTIVATE,
        ST_RCD_WAIT,
        ST_COLUMN,
        ST_RECOVER
    } seq_state_t;

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
    parameter int TW      = 6,
    parameter int RST_VAL = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= TW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cl3,
    input  logic [DW-1:0] dq_in,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    logic [1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (start)
                cnt <= cl3 ? 2'd3 : 2'd2;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (!start && cnt == 2'd1) begin
                rsp_valid <= 1'b1;
                rsp_data  <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int T_INIT = 20,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RC   = 9,
    parameter int T_DPL  = 2,
    parameter int T_MRD  = 2,
    parameter int BAW    = 2,
    parameter int ROWW   = 13,
    parameter int COLW   = 9,
    parameter int DW     = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cas_lat3,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [BAW-1:0]  req_bank,
    input  logic [ROWW-1:0] req_row,
    input  logic [COLW-1:0] req_col,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic            sd_cs_n,
    output logic            sd_ras_n,
    output logic            sd_cas_n,
    output logic            sd_we_n,
    output logic [BAW-1:0]  sd_ba,
    output logic [ROWW-1:0] sd_addr,
    output logic            sd_dqm,
    output logic [DW-1:0]   sd_dq_out,
    output logic            sd_dq_oe,
    input  logic [DW-1:0]   sd_dq_in
);
    localparam int GAP_ACT = T_RC - T_RCD;
    localparam int GAP_PRE = T_DPL + T_RP;
    localparam int COL_GAP = (GAP_ACT > GAP_PRE) ? GAP_ACT : GAP_PRE;
    localparam int TW      = $clog2(T_INIT + COL_GAP + T_RC + 2) + 1;

    seq_state_t state, state_nx;
    sd_cmd_t    cmd;
    logic            cl_prog;
    logic            lat_wr;
    logic [BAW-1:0]  lat_bank;
    logic [ROWW-1:0] lat_row;
    logic [COLW-1:0] lat_col;
    logic [DW-1:0]   lat_wdata;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic            accept;

    assign req_ready = (state == ST_IDLE) && (cas_lat3 == cl_prog);
    assign accept    = req_ready && req_valid;

    // next state and timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_INIT_WAIT: if (tmr_done) state_nx = ST_INIT_PRE;
            ST_INIT_PRE: begin
                state_nx = ST_PRE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RP - 2);
            end
            ST_PRE_WAIT:  if (tmr_done) state_nx = ST_LOAD_MODE;
            ST_LOAD_MODE: begin
                state_nx = ST_MODE_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_MRD - 2);
            end
            ST_MODE_WAIT: if (tmr_done) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (cas_lat3 != cl_prog) state_nx = ST_LOAD_MODE;
                else if (req_valid)      state_nx = ST_ACTIVATE;
            end
            ST_ACTIVATE: begin
                state_nx = ST_RCD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RCD - 2);
            end
            ST_RCD_WAIT:  if (tmr_done) state_nx = ST_COLUMN;
            ST_COLUMN: begin
                state_nx = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = TW'(COL_GAP - 3);
            end
            ST_RECOVER:   if (tmr_done) state_nx = ST_IDLE;
            default:      state_nx = ST_INIT_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT_WAIT;
        else        state <= state_nx;
    end

    // request latch and programmed latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cl_prog   <= 1'b0;
            lat_wr    <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
        end else begin
            if (state == ST_LOAD_MODE) cl_prog <= cas_lat3;
            if (accept) begin
                lat_wr    <= req_write;
                lat_bank  <= req_bank;
                lat_row   <= req_row;
                lat_col   <= req_col;
                lat_wdata <= req_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = '0;
        sd_addr   = '0;
        sd_dqm    = 1'b0;
        sd_dq_oe  = 1'b0;
        sd_dq_out = lat_wdata;
        unique case (state)
            ST_INIT_WAIT, ST_PRE_WAIT: sd_dqm = 1'b1;
            ST_INIT_PRE: begin
                cmd         = CMD_PRE;
                sd_dqm      = 1'b1;
                sd_addr[10] = 1'b1;
            end
            ST_LOAD_MODE: begin
                cmd          = CMD_MRS;
                sd_dqm       = 1'b1;
                sd_addr[6:4] = {2'b01, cas_lat3};
            end
            ST_ACTIVATE: begin
                cmd     = CMD_ACT;
                sd_ba   = lat_bank;
                sd_addr = lat_row;
            end
            ST_COLUMN: begin
                cmd               = lat_wr ? CMD_WR : CMD_RD;
                sd_ba             = lat_bank;
                sd_addr[COLW-1:0] = lat_col;
                sd_addr[10]       = 1'b1;
                sd_dq_oe          = lat_wr;
            end
            ST_MODE_WAIT, ST_IDLE, ST_RCD_WAIT, ST_RECOVER: ;
            default: sd_dqm = 1'b1;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdram_seq_timer #(.TW(TW), .RST_VAL(T_INIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sdram_seq_rdcap #(.DW(DW)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd == CMD_RD),
        .cl3       (cl_prog),
        .dq_in     (sd_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_DPL = 2,
    parameter int T_MRD = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sd_cs_n,
    input logic        sd_ras_n,
    input logic        sd_cas_n,
    input logic        sd_we_n,
    input logic [12:0] sd_addr,
    input logic        sd_dq_oe,
    input logic        rsp_valid,
    input logic        req_ready
);
    localparam int GAP_ACT = T_RC - T_RCD;
    localparam int GAP_PRE = T_DPL + T_RP;
    localparam int COL_GAP = (GAP_ACT > GAP_PRE) ? GAP_ACT : GAP_PRE;

    logic [3:0] cmd;
    logic       is_act, is_col, is_wr, is_mrs, is_nop;
    logic [7:0] since_act, since_col, since_mrs;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_wr  = (cmd == 4'b0100);
    assign is_col = (cmd == 4'b0101) || is_wr;
    assign is_mrs = (cmd == 4'b0000);
    assign is_nop = (cmd == 4'b0111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act <= 8'hFF;
            since_col <= 8'hFF;
            since_mrs <= 8'hFF;
        end else begin
            since_act <= is_act ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
            since_col <= is_col ? 8'd1 : (since_col == 8'hFF ? since_col : since_col + 8'd1);
            since_mrs <= is_mrs ? 8'd1 : (since_mrs == 8'hFF ? since_mrs : since_mrs + 8'd1);
        end
    end

    AST_RCD_EXACT:  assert property (@(posedge clk) disable iff (!rst_n) is_col |-> since_act == 8'(T_RCD)); // R4
    AST_AUTO_PRE:   assert property (@(posedge clk) disable iff (!rst_n) is_col |-> sd_addr[10]); // R4
    AST_ROW_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) is_act |-> since_act >= 8'(T_RC)); // R5
    AST_COL_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> since_col >= 8'(COL_GAP)); // R5
    AST_OE_WRITE:   assert property (@(posedge clk) disable iff (!rst_n) sd_dq_oe |-> is_wr); // R6
    AST_RSP_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R7
    AST_READY_NOP:  assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> is_nop); // R8
    AST_MRS_GAP:    assert property (@(posedge clk) disable iff (!rst_n) !is_nop |-> since_mrs >= 8'(T_MRD)); // R10
endmodule

bind sdram_seq sdram_seq_chk #(
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_RC  (T_RC),
    .T_DPL (T_DPL),
    .T_MRD (T_MRD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_dq_oe  (sd_dq_oe),
    .rsp_valid (rsp_valid),
    .req_ready (req_ready)
);

// File: tb/sdram_seq_bench.sv
module sdram_seq_bench;
    localparam int T_INIT  = 20;
    localparam int T_RCD   = 3;
    localparam int T_RP    = 3;
    localparam int T_RC    = 9;
    localparam int T_DPL   = 2;
    localparam int T_MRD   = 2;
    localparam int COL_GAP = 6;
    localparam int NV      = 7;

    // {write, cl3, bank, row, col, data}
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'd0, 13'd5,    9'd3,   16'h1234},
        {1'b0, 1'b1, 2'd0, 13'd5,    9'd3,   16'h1234},
        {1'b1, 1'b1, 2'd3, 13'h1FFF, 9'h1FF, 16'hBEEF},
        {1'b0, 1'b0, 2'd3, 13'h1FFF, 9'h1FF, 16'hBEEF},
        {1'b1, 1'b0, 2'd1, 13'd0,    9'd0,   16'h0F0F},
        {1'b0, 1'b1, 2'd1, 13'd0,    9'd0,   16'h0F0F},
        {1'b0, 1'b1, 2'd0, 13'd5,    9'd3,   16'h1234}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cas_lat3 = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0] req_col = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
    logic [1:0] sd_ba;
    logic [12:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = 16'hDEAD;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_seq u_sdram_seq (
        .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ideal memory and command monitor, sampled mid-cycle
    logic [15:0] mem [int];
    logic [12:0] open_row [4];
    int cyc = 0, last_act = -1000, last_col = -1000, last_mrs = -1000, rd_cyc = -1000, pre_cyc = -1000;
    int mdl_cl = 2, rd_cnt = 0, mrs_cnt = 0, act_cnt = 0;
    bit init_seen = 0;
    logic [15:0] rd_val = '0;
    logic cur_cl3 = 1'b1;
    logic [1:0] cur_bank = '0;
    logic [15:0] cur_data = '0;

    always @(negedge clk) begin
        logic [3:0] cmd;
        int key;
        cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst_n) begin
            init_seen = 0; rd_cnt = 0; last_act = -1000; last_col = -1000; last_mrs = -1000;
            sd_dq_in = 16'hDEAD;
        end else begin
            cyc++;
            if (rd_cnt == 1) sd_dq_in = rd_val; else sd_dq_in = 16'hDEAD;
            if (rd_cnt != 0) rd_cnt--;
            if (req_ready && !init_seen) chk(0, "R8", "ready before mode set", 1, 0);
            if (cmd != 4'b0111 && cmd != 4'b0011 && cmd != 4'b0101 && cmd != 4'b0100
                && cmd != 4'b0010 && cmd != 4'b0000)
                chk(0, "R10", "illegal command", cmd, 4'b0111);
            if (cmd != 4'b0111 && last_mrs > -1000)
                chk(cyc - last_mrs >= T_MRD, "R10", "mrs to next gap", cyc - last_mrs, T_MRD);
            if (sd_dq_oe && cmd != 4'b0100) chk(0, "R6", "oe outside write", 1, 0);
            if (rsp_valid) chk(cyc - rd_cyc == mdl_cl + 1, "R7", "response delay", cyc - rd_cyc, mdl_cl + 1);
            case (cmd)
                4'b0010: if (!init_seen) begin
                    chk(sd_addr[10] == 1'b1, "R2", "precharge all flag", sd_addr[10], 1);
                    chk(cyc > T_INIT, "R2", "init wait", cyc, T_INIT);
                    pre_cyc = cyc;
                end
                4'b0000: begin
                    mrs_cnt++;
                    chk(sd_addr == {6'b0, 2'b01, cas_lat3, 4'b0}, "R3", "mode word", sd_addr, {6'b0, 2'b01, cas_lat3, 4'b0});
                    chk(sd_ba == 2'd0, "R3", "mode bank", sd_ba, 0);
                    if (!init_seen) begin
                        chk(cyc - pre_cyc == T_RP, "R2", "precharge to mode gap", cyc - pre_cyc, T_RP);
                        init_seen = 1;
                    end
                    mdl_cl = sd_addr[4] ? 3 : 2;
                    last_mrs = cyc;
                end
                4'b0011: begin
                    act_cnt++;
                    chk(cyc - last_act >= T_RC, "R5", "act to act", cyc - last_act, T_RC);
                    chk(cyc - last_col >= COL_GAP, "R5", "col to act", cyc - last_col, COL_GAP);
                    chk(mdl_cl == (cur_cl3 ? 3 : 2), "R9", "latency in force", mdl_cl, cur_cl3 ? 3 : 2);
                    open_row[sd_ba] = sd_addr;
                    last_act = cyc;
                end
                4'b0101, 4'b0100: begin
                    chk(cyc - last_act == T_RCD, "R4", "act to column", cyc - last_act, T_RCD);
                    chk(sd_addr[10] == 1'b1, "R4", "auto-precharge flag", sd_addr[10], 1);
                    chk(sd_ba == cur_bank, "R4", "column bank", sd_ba, cur_bank);
                    key = int'({sd_ba, open_row[sd_ba], sd_addr[8:0]});
                    if (cmd == 4'b0100) begin
                        chk(sd_dq_oe && sd_dq_out == cur_data, "R6", "write data", sd_dq_out, cur_data);
                        chk(sd_dqm == 1'b0, "R6", "write mask", sd_dqm, 0);
                        mem[key] = sd_dq_out;
                    end else begin
                        rd_val = mem.exists(key) ? mem[key] : 16'h0000;
                        rd_cnt = mdl_cl;
                        rd_cyc = cyc;
                    end
                    last_col = cyc;
                end
                default: ;
            endcase
        end
    end

    task automatic run_req(input logic [41:0] v);
        cur_cl3  = v[40];
        cur_bank = v[39:38];
        cur_data = v[15:0];
        @(negedge clk);
        cas_lat3  = v[40];
        req_valid = 1'b1;
        req_write = v[41];
        req_bank  = v[39:38];
        req_row   = v[37:25];
        req_col   = v[24:16];
        req_wdata = v[15:0];
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8", "ready after accept", req_ready, 0);
        if (!v[41]) begin
            while (!rsp_valid) @(negedge clk);
            chk(rsp_rdata == v[15:0], "R7", "read data", rsp_rdata, v[15:0]);
        end
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(sd_dqm == 1'b1, "R1", "reset mask", sd_dqm, 1);
        chk(!req_ready && !rsp_valid, "R1", "reset handshake", {req_ready, rsp_valid}, 0);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk(mrs_cnt == 1, "R2", "mode sets after init", mrs_cnt, 1);
        for (int i = 0; i < NV; i++) run_req(VEC[i]);
        chk(act_cnt == NV, "R8", "activates per request", act_cnt, NV);
        chk(mrs_cnt == 3, "R9", "mode sets after latency changes", mrs_cnt, 3);
        // reset while a write is in flight
        cur_cl3 = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "mid-run reset command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(sd_dqm && !req_ready && !sd_dq_oe, "R1", "mid-run reset outputs", {sd_dqm, req_ready, sd_dq_oe}, 3'b100);
        @(negedge clk);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk(init_seen == 1, "R2", "reinit sequence", init_seen, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule